// File: doc/BRIEF.md
# Graphic LCD Command Decoder

This block sits between a host processor and the rest of a character/graphic LCD controller. The host writes bytes over a parallel bus. A select line marks each byte as either a command or a data byte. Data bytes are argument bytes: the block keeps the two most recent ones. A command byte arrives after its arguments. Its upper bits pick a register family, and its lower bits pick a register within that family or supply a field value directly.

The decoded configuration drives downstream rendering and timing logic. This configuration covers:
- cursor position
- character-generator RAM offset
- address pointer
- text and graphic home addresses and row widths
- merge mode
- display enables
- cursor height

Commands that move display memory contents are not executed here. They are recognised and passed on as a one-cycle strobe that carries the opcode. Each accepted command makes the block busy for a fixed number of cycles. While it is busy, its ready flags are low and it drops any byte the host writes.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: A data byte (cmd_sel=0) shifts the argument pair: the earlier of the last two data bytes is the low argument and the later is the high argument. A 16-bit register takes {high, low}. Data bytes do not start a busy period.
- R2: Command 0x21 loads cursor column from low argument bits 6:0 and cursor row from high argument bits 4:0. No other command or data byte changes the cursor.
- R3: Command 0x22 loads the CG offset from low argument bits 4:0. Command 0x24 loads the address pointer with {high, low}.
- R4: Commands 0x40 and 0x42 load the text home and graphic home addresses with {high, low}. Commands 0x41 and 0x43 load the text and graphic column counts from the low argument only.
- R5: For an opcode 0x80-0x8F, bit 3 is the all-RAM character flag and bits 2:0 are the merge mode. The legal merge modes are 000 OR, 001 XOR, 011 AND and 100 text-with-attribute. A legal mode updates both fields. Any other mode code changes neither field.
- R6: For an opcode 0x90-0x9F, bits 3,2,1,0 set graphic_on, text_on, cursor_on and blink_on.
- R7: For an opcode 0xA0-0xA7, cursor_lines becomes opcode bits 2:0 plus one, a value from 1 to 8.
- R8: An accepted command holds status bits 0 and 1 low for exactly BUSY_CYCLES cycles, starting with the cycle after the accepting edge. Any byte written while those bits are low is dropped.
- R9: An opcode outside the defined set (for example 0x00, 0x23, 0x85, 0xA8, 0xD3) changes no register but still starts the busy period.
- R10: status bit 0 and bit 1 are the ready flags, and bit 3 is auto-transfer mode. Bit 6 is the peek/copy error flag and reads 0. All other bits read 0. Opcodes 0xB0/0xB1 set bit 3, and 0xB2/0xB3 clear it.
- R11: Transfer opcodes raise xfer_go for exactly one cycle, the cycle after acceptance, with xfer_op equal to the opcode. The transfer opcodes are 0xC0-0xC7, 0xE0, 0xE8 and 0xF0-0xFF. No other byte raises xfer_go.
- R12: After reset, the block is ready and every register is zero, except cursor_lines, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, sampled on the rising edge |
| cmd_sel | input | 1 | 1 = command byte, 0 = data byte |
| wr_data | input | 8 | Host byte |
| status | output | 8 | Status byte (ready, auto mode, error) |
| cur_col | output | 7 | Cursor column |
| cur_row | output | 5 | Cursor row |
| cg_offset | output | 5 | CG RAM offset (upper address bits) |
| addr_ptr | output | 16 | Display memory address pointer |
| text_home | output | 16 | Text area start address |
| text_cols | output | 8 | Text columns per row |
| graph_home | output | 16 | Graphic area start address |
| graph_cols | output | 8 | Graphic columns per row |
| cg_ram_only | output | 1 | All characters from CG RAM |
| merge_mode | output | 3 | Text/graphic merge mode |
| graphic_on | output | 1 | Graphic layer enable |
| text_on | output | 1 | Text layer enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| cursor_lines | output | 4 | Cursor height in lines (1-8) |
| xfer_go | output | 1 | One-cycle transfer command strobe |
| xfer_op | output | 8 | Opcode of the transfer command |

## Verification
The bench builds the block with BUSY_CYCLES=5. This keeps each command round trip at about a dozen cycles, so several hundred random opcode/argument combinations fit comfortably in the run. The short busy window also makes it cheap to count the exact number of low-ready cycles and to aim writes inside the window, including at its first and last cycles. Random opcodes cover the whole byte range, which reaches the undefined codes in every family alongside the directed cases.

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder #(
  parameter int BUSY_CYCLES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        cmd_sel,
  input  logic [7:0]  wr_data,
  output logic [7:0]  status,
  output logic [6:0]  cur_col,
  output logic [4:0]  cur_row,
  output logic [4:0]  cg_offset,
  output logic [15:0] addr_ptr,
  output logic [15:0] text_home,
  output logic [7:0]  text_cols,
  output logic [15:0] graph_home,
  output logic [7:0]  graph_cols,
  output logic        cg_ram_only,
  output logic [2:0]  merge_mode,
  output logic        graphic_on,
  output logic        text_on,
  output logic        cursor_on,
  output logic        blink_on,
  output logic [3:0]  cursor_lines,
  output logic        xfer_go,
  output logic [7:0]  xfer_op
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] busy_cnt;
  logic [7:0]    arg_lo, arg_hi;
  logic          auto_mode;
  logic          ready, take, take_cmd;
  logic          mode_legal, is_xfer;

  assign ready    = (busy_cnt == '0);
  assign take     = wr_en && ready;
  assign take_cmd = take && cmd_sel;
  assign status   = {4'b0000, auto_mode, 1'b0, ready, ready};

  assign mode_legal = (wr_data[2:0] == 3'b000) || (wr_data[2:0] == 3'b001) ||
                      (wr_data[2:0] == 3'b011) || (wr_data[2:0] == 3'b100);
  assign is_xfer = (wr_data[7:3] == 5'b11000) || (wr_data == 8'hE0) ||
                   (wr_data == 8'hE8) || (wr_data[7:4] == 4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt     <= '0;
      arg_lo       <= '0;
      arg_hi       <= '0;
      auto_mode    <= 1'b0;
      cur_col      <= '0;
      cur_row      <= '0;
      cg_offset    <= '0;
      addr_ptr     <= '0;
      text_home    <= '0;
      text_cols    <= '0;
      graph_home   <= '0;
      graph_cols   <= '0;
      cg_ram_only  <= 1'b0;
      merge_mode   <= '0;
      graphic_on   <= 1'b0;
      text_on      <= 1'b0;
      cursor_on    <= 1'b0;
      blink_on     <= 1'b0;
      cursor_lines <= 4'd1;
      xfer_go      <= 1'b0;
      xfer_op      <= '0;
    end else begin
      xfer_go <= 1'b0;
      if (!ready) busy_cnt <= busy_cnt - 1'b1;
      if (take && !cmd_sel) begin
        arg_lo <= arg_hi;
        arg_hi <= wr_data;
      end
      if (take_cmd) begin
        busy_cnt <= BUSY_LOAD;
        case (wr_data)
          8'h21: begin
            cur_col <= arg_lo[6:0];
            cur_row <= arg_hi[4:0];
          end
          8'h22: cg_offset  <= arg_lo[4:0];
          8'h24: addr_ptr   <= {arg_hi, arg_lo};
          8'h40: text_home  <= {arg_hi, arg_lo};
          8'h41: text_cols  <= arg_lo;
          8'h42: graph_home <= {arg_hi, arg_lo};
          8'h43: graph_cols <= arg_lo;
          8'hB0, 8'hB1: auto_mode <= 1'b1;
          8'hB2, 8'hB3: auto_mode <= 1'b0;
          default: begin
            if (wr_data[7:4] == 4'h8 && mode_legal) begin
              cg_ram_only <= wr_data[3];
              merge_mode  <= wr_data[2:0];
            end
            if (wr_data[7:4] == 4'h9) begin
              graphic_on <= wr_data[3];
              text_on    <= wr_data[2];
              cursor_on  <= wr_data[1];
              blink_on   <= wr_data[0];
            end
            if (wr_data[7:3] == 5'b10100)
              cursor_lines <= {1'b0, wr_data[2:0]} + 4'd1;
            if (is_xfer) begin
              xfer_go <= 1'b1;
              xfer_op <= wr_data;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
module lcd_cmd_decoder_chk #(
  parameter int BUSY_CYCLES = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        cmd_sel,
  input logic [7:0]  wr_data,
  input logic [7:0]  status,
  input logic [6:0]  cur_col,
  input logic [4:0]  cur_row,
  input logic [2:0]  merge_mode,
  input logic        cg_ram_only,
  input logic        xfer_go
);
  logic [15:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (status[0]) low_run <= '0;
    else low_run <= low_run + 16'd1;
  end

  logic accept_cmd;
  assign accept_cmd = wr_en && cmd_sel && status[0];

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(BUSY_CYCLES));

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $past(wr_en && cmd_sel));

  assert_cursor_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_cmd && wr_data == 8'h21) |=> $stable(cur_col) && $stable(cur_row));

  assert_bad_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_cmd && wr_data[7:4] == 4'h8 &&
     (wr_data[2:0] == 3'b010 || wr_data[2:0] > 3'b100))
    |=> $stable(merge_mode) && $stable(cg_ram_only));

  assert_xfer_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> $past(accept_cmd));

  assert_xfer_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);

  assert_status_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'b0000 && status[2] == 1'b0);
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_sel(cmd_sel), .wr_data(wr_data),
  .status(status), .cur_col(cur_col), .cur_row(cur_row), .merge_mode(merge_mode),
  .cg_ram_only(cg_ram_only), .xfer_go(xfer_go)
);

// File: tb/lcd_cmd_decoder_test.sv
module lcd_cmd_decoder_test;
  localparam int BUSY = 5;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic [6:0] cur_col;
  logic [4:0] cur_row, cg_offset;
  logic [15:0] addr_ptr, text_home, graph_home;
  logic [7:0] text_cols, graph_cols, xfer_op;
  logic cg_ram_only, graphic_on, text_on, cursor_on, blink_on, xfer_go;
  logic [2:0] merge_mode;
  logic [3:0] cursor_lines;

  always #4 clk = ~clk;

  lcd_cmd_decoder #(.BUSY_CYCLES(BUSY)) uut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] e_lo, e_hi, e_tcols, e_gcols;
  logic [6:0] e_col;
  logic [4:0] e_row, e_off;
  logic [15:0] e_addr, e_thome, e_ghome;
  logic e_cg, e_auto;
  logic [2:0] e_mode;
  logic [3:0] e_disp, e_lines;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit xfer_code(logic [7:0] op);
    return (op >= 8'hC0 && op <= 8'hC7) || op == 8'hE0 || op == 8'hE8 || op >= 8'hF0;
  endfunction

  task automatic model_reset();
    e_lo = 0; e_hi = 0; e_col = 0; e_row = 0; e_off = 0; e_addr = 0;
    e_thome = 0; e_ghome = 0; e_tcols = 0; e_gcols = 0; e_cg = 0; e_mode = 0;
    e_disp = 0; e_lines = 1; e_auto = 0;
  endtask

  task automatic model_cmd(logic [7:0] op);
    if (op == 8'h21) begin e_col = e_lo[6:0]; e_row = e_hi[4:0]; end
    else if (op == 8'h22) e_off = e_lo[4:0];
    else if (op == 8'h24) e_addr = {e_hi, e_lo};
    else if (op == 8'h40) e_thome = {e_hi, e_lo};
    else if (op == 8'h41) e_tcols = e_lo;
    else if (op == 8'h42) e_ghome = {e_hi, e_lo};
    else if (op == 8'h43) e_gcols = e_lo;
    else if (op >= 8'h80 && op <= 8'h8F) begin
      if (op[2:0] inside {3'd0, 3'd1, 3'd3, 3'd4}) begin e_cg = op[3]; e_mode = op[2:0]; end
    end
    else if (op >= 8'h90 && op <= 8'h9F) e_disp = op[3:0];
    else if (op >= 8'hA0 && op <= 8'hA7) e_lines = 4'(op[2:0]) + 4'd1;
    else if (op == 8'hB0 || op == 8'hB1) e_auto = 1;
    else if (op == 8'hB2 || op == 8'hB3) e_auto = 0;
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!status[0]) @(negedge clk);
  endtask

  task automatic put_data(logic [7:0] d);
    wait_ready();
    wr_en = 1; cmd_sel = 0; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    e_lo = e_hi; e_hi = d;
    chk("R1", "ready after data", 32'(status[0]), 32'd1);
  endtask

  task automatic put_cmd(logic [7:0] op);
    wait_ready();
    wr_en = 1; cmd_sel = 1; wr_data = op;
    @(negedge clk);
    wr_en = 0;
    model_cmd(op);
    chk("R11", "xfer_go", 32'(xfer_go), 32'(xfer_code(op)));
    if (xfer_code(op)) chk("R11", "xfer_op", 32'(xfer_op), 32'(op));
  endtask

  task automatic check_all(string req);
    wait_ready();
    chk(req, "status", 32'(status), 32'({4'b0, e_auto, 1'b0, 2'b11}));
    chk(req, "cur_col", 32'(cur_col), 32'(e_col));
    chk(req, "cur_row", 32'(cur_row), 32'(e_row));
    chk(req, "cg_offset", 32'(cg_offset), 32'(e_off));
    chk(req, "addr_ptr", 32'(addr_ptr), 32'(e_addr));
    chk(req, "text_home", 32'(text_home), 32'(e_thome));
    chk(req, "text_cols", 32'(text_cols), 32'(e_tcols));
    chk(req, "graph_home", 32'(graph_home), 32'(e_ghome));
    chk(req, "graph_cols", 32'(graph_cols), 32'(e_gcols));
    chk(req, "cg_ram_only", 32'(cg_ram_only), 32'(e_cg));
    chk(req, "merge_mode", 32'(merge_mode), 32'(e_mode));
    chk(req, "display", 32'({graphic_on, text_on, cursor_on, blink_on}), 32'(e_disp));
    chk(req, "cursor_lines", 32'(cursor_lines), 32'(e_lines));
    chk(req, "xfer_go idle", 32'(xfer_go), 32'd0);
  endtask

  task automatic run3(logic [7:0] a, logic [7:0] b, logic [7:0] op, string req);
    put_data(a); put_data(b); put_cmd(op); check_all(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] defined [22] = '{8'h21, 8'h22, 8'h24, 8'h40, 8'h41, 8'h42, 8'h43,
      8'h80, 8'h89, 8'h83, 8'h8C, 8'h9F, 8'h95, 8'hA0, 8'hA7, 8'hB0, 8'hB2,
      8'hC0, 8'hC5, 8'hE0, 8'hE8, 8'hFB};
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R12");

    run3(8'hA5, 8'h3C, 8'h24, "R1");
    run3(8'hFF, 8'hFF, 8'h21, "R2");
    run3(8'h12, 8'h34, 8'h22, "R3");
    run3(8'h78, 8'h56, 8'h40, "R4");
    run3(8'h28, 8'h99, 8'h41, "R4");
    run3(8'h00, 8'h80, 8'h42, "R4");
    run3(8'h1E, 8'h00, 8'h43, "R4");
    run3(8'h00, 8'h00, 8'h8B, "R5");
    run3(8'h00, 8'h00, 8'h8A, "R5");
    run3(8'h00, 8'h00, 8'h87, "R5");
    run3(8'h00, 8'h00, 8'h9D, "R6");
    run3(8'h00, 8'h00, 8'hA7, "R7");
    run3(8'h00, 8'h00, 8'hA8, "R9");
    run3(8'h55, 8'h66, 8'h23, "R9");
    run3(8'h55, 8'h66, 8'h00, "R9");
    run3(8'h00, 8'h00, 8'hB1, "R10");
    run3(8'h00, 8'h00, 8'hB3, "R10");
    run3(8'h00, 8'h00, 8'hE8, "R11");
    run3(8'h00, 8'h00, 8'hE1, "R11");

    put_data(8'h05); put_data(8'h03); put_cmd(8'h21);
    put_data(8'h44); put_data(8'h11); put_cmd(8'hC0); put_data(8'h7F); put_cmd(8'hC4);
    check_all("R2");

    put_data(8'h11); put_data(8'h22);
    wait_ready();
    wr_en = 1; cmd_sel = 1; wr_data = 8'h24;
    @(negedge clk);
    model_cmd(8'h24);
    cmd_sel = 0; wr_data = 8'h99;
    begin
      int lows = 0;
      while (!status[0]) begin
        lows++;
        @(negedge clk);
        if (lows == 1) begin cmd_sel = 1; wr_data = 8'h21; end
        if (lows == BUSY - 1) begin cmd_sel = 0; wr_data = 8'h77; end
        if (lows > 4 * BUSY) break;
      end
      wr_en = 0;
      chk("R8", "busy cycles", 32'(lows), 32'(BUSY));
    end
    check_all("R8");
    put_cmd(8'h24);
    check_all("R8");

    for (int i = 0; i < 300; i++) begin
      logic [7:0] op;
      if ($urandom % 3 == 0) op = 8'($urandom);
      else op = defined[$urandom % 22];
      run3(8'($urandom), 8'($urandom), op, "R9");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule